// File: doc/BRIEF.md
# Bus-Attached UART with Ready Interrupts

This block is an asynchronous serial transceiver that sits on a simple synchronous slave bus. A bus write to the data register starts serialisation of that byte on the transmit line. Incoming serial frames are sampled, checked and stored. Two interrupt lines carry handshake meaning. The transmit line of the pair is high while the transmitter can take a byte, and its rising edge asks for the next one. The receive line of the pair is raised when a good frame is complete and is dropped by the bus read that consumes the byte.

Frames are 8N1: one low start bit, eight data bits with the least significant bit first, and one high stop bit. The line idles high. One bit lasts `16 * CLK_PER_TICK` clocks. The receiver counts a 16x oversampling tick that is divided down from the bus clock. It qualifies a start bit at its centre and samples every later bit at its centre.

Every bus transfer is a single-cycle strobe. The slave acknowledges it in the following cycle, and read data is valid in that same cycle. Register map: address 0 is the data register (write sends a byte, read returns the received byte). Address 1 is status, read only. Addresses 2 and 3 read as zero.

Top module: `uart_bus_slave`

## Requirements
- R1: A write to address 0 while the transmitter is idle sends a frame on `txd_o`. The line goes low at the clock edge that samples the strobe. The frame is start bit 0, data bits LSB first, then stop bit 1, and each bit lasts exactly 16*CLK_PER_TICK clocks.
- R2: `tx_irq_o` is high while the transmitter is idle. It is low from the accepting edge for exactly 10 bit times, and then returns high.
- R3: A write to address 0 while a frame is in progress is dropped. The current frame is unchanged, and no second frame follows it.
- R4: After a valid frame, `rx_irq_o` goes high and a read of address 0 returns the received byte.
- R5: A read of address 0 drops `rx_irq_o`, which is already low in the acknowledge cycle of that read.
- R6: A low pulse on `rxd_i` that is shorter than half a bit is rejected as a false start and raises no interrupt. A valid frame after it is still received correctly.
- R7: A frame whose stop bit is low at its centre is discarded: `rx_irq_o` stays low.
- R8: A frame that completes while the previous byte is still unread replaces the data and sets the overrun flag. A read of status clears the overrun flag.
- R9: `ack_o` is high for exactly one clock, in the cycle after each strobe, for reads and writes alike. `rdata_o` is valid in that cycle.
- R10: The status register (address 1) has bit 0 = receive byte ready, bit 1 = transmitter idle, bit 2 = overrun, and all other bits are zero. Writes to address 1 have no effect. Addresses 2 and 3 read as 0.
- R11: After reset, `txd_o` and `tx_irq_o` are high, and `rx_irq_o` and `ack_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stb_i | input | 1 | Transfer strobe, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid with ack |
| ack_o | output | 1 | Transfer acknowledge |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |
| tx_irq_o | output | 1 | Transmitter ready for a byte |
| rx_irq_o | output | 1 | Received byte waiting |

## Verification
The transmitter is tested with a fixed alternating byte and with seeded random bytes. A write is injected into the middle of a frame, which tells a dropped write apart from a reload or a queued frame. The receiver is tested with random frames read one at a time, with a sub-half-bit low glitch, with a frame whose stop bit is low at its centre, and with two frames back to back and no read between them. These cases tell false-start rejection, stop-bit checking and overrun replacement apart from plain reception. Bus accesses to the status register and the unused addresses confirm the flag encoding, and confirm that writes to status have no effect.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int unsigned OVS = 16;  // oversampling ticks per bit

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/baud_tick.sv
module baud_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV > 1) begin : g_cnt
      localparam int unsigned CW = $clog2(DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q  <= '0;
          tick_o <= 1'b0;
        end else if (cnt_q == CW'(DIV - 1)) begin
          cnt_q  <= '0;
          tick_o <= 1'b1;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
          tick_o <= 1'b0;
        end
      end

      a_r6_tick_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end else begin : g_pass
      assign tick_o = rst_ni;
    end
  endgenerate
endmodule

// File: rtl/ser_tx.sv
module ser_tx #(
  parameter int unsigned DW       = 8,
  parameter int unsigned BIT_CLKS = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          txd_o
);
  localparam int unsigned CW = $clog2(BIT_CLKS);
  localparam int unsigned BW = $clog2(DW + 2);

  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bitn_q;
  logic [DW:0]   sh_q;   // data bits then stop bit
  logic          busy_q;
  logic          txd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
      cnt_q  <= '0;
      bitn_q <= '0;
      sh_q   <= '0;
    end else if (load_i && !busy_q) begin
      busy_q <= 1'b1;
      txd_q  <= 1'b0;
      sh_q   <= {1'b1, data_i};
      cnt_q  <= '0;
      bitn_q <= '0;
    end else if (busy_q) begin
      if (cnt_q == CW'(BIT_CLKS - 1)) begin
        cnt_q <= '0;
        if (bitn_q == BW'(DW + 1)) begin
          busy_q <= 1'b0;
          txd_q  <= 1'b1;
        end else begin
          txd_q  <= sh_q[0];
          sh_q   <= {1'b0, sh_q[DW:1]};
          bitn_q <= bitn_q + 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = txd_q;

  a_r1_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> txd_q);
  a_r1_load_starts_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !busy_q) |=> (busy_q && !txd_q));
  a_r3_busy_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && load_i && cnt_q != CW'(BIT_CLKS - 1)) |=> $stable(txd_q));
endmodule

// File: rtl/ser_rx.sv
module ser_rx
  import ser_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rxd_i,
  output logic          done_o,
  output logic [DW-1:0] data_o
);
  localparam int unsigned TW = $clog2(OVS);
  localparam int unsigned BW = $clog2(DW);

  logic [1:0]    sync_q;
  logic          rxs;
  rx_state_e     state_q;
  logic [TW-1:0] tcnt_q;
  logic [BW-1:0] bitn_q;
  logic [DW-1:0] sh_q;
  logic [DW-1:0] data_q;
  logic          done_q;

  assign rxs = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      tcnt_q  <= '0;
      bitn_q  <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          RX_IDLE: if (!rxs) begin
            state_q <= RX_START;
            tcnt_q  <= '0;
          end
          RX_START: begin
            if (tcnt_q == TW'(OVS / 2 - 1)) begin
              tcnt_q <= '0;
              bitn_q <= '0;
              state_q <= rxs ? RX_IDLE : RX_DATA;  // high at centre: glitch
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (tcnt_q == TW'(OVS - 1)) begin
              tcnt_q <= '0;
              sh_q   <= {rxs, sh_q[DW-1:1]};
              if (bitn_q == BW'(DW - 1)) state_q <= RX_STOP;
              else                       bitn_q  <= bitn_q + 1'b1;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (tcnt_q == TW'(OVS - 1)) begin
              tcnt_q  <= '0;
              state_q <= RX_IDLE;
              if (rxs) begin
                done_q <= 1'b1;
                data_q <= sh_q;
              end
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign done_o = done_q;
  assign data_o = data_q;

  a_r7_done_needs_stop_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(rxs));
  a_r6_done_from_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(state_q == RX_STOP));
endmodule

// File: rtl/uart_bus_slave.sv
module uart_bus_slave
  import ser_pkg::*;
#(
  parameter int unsigned CLK_PER_TICK = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stb_i,
  input  logic       we_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       ack_o,
  output logic       txd_o,
  input  logic       rxd_i,
  output logic       tx_irq_o,
  output logic       rx_irq_o
);
  localparam int unsigned DW       = 8;
  localparam int unsigned BIT_CLKS = OVS * CLK_PER_TICK;

  logic          ack_q;
  logic [DW-1:0] rdata_q;
  logic          acc, wr, rd;
  logic          tx_load, tx_busy;
  logic          tick;
  logic          rx_done;
  logic [DW-1:0] rx_data;
  logic          rx_rdy_q, ovr_q;
  logic          rd_data, rd_stat;
  logic [DW-1:0] rd_mux;

  assign acc     = stb_i && !ack_q;
  assign wr      = acc && we_i;
  assign rd      = acc && !we_i;
  assign tx_load = wr && (addr_i == ADDR_DATA);
  assign rd_data = rd && (addr_i == ADDR_DATA);
  assign rd_stat = rd && (addr_i == ADDR_STAT);

  baud_tick #(.DIV(CLK_PER_TICK)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  ser_tx #(.DW(DW), .BIT_CLKS(BIT_CLKS)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tx_load),
    .data_i (wdata_i),
    .busy_o (tx_busy),
    .txd_o  (txd_o)
  );

  ser_rx #(.DW(DW)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .rxd_i  (rxd_i),
    .done_o (rx_done),
    .data_o (rx_data)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_DATA: rd_mux = rx_data;
      ADDR_STAT: rd_mux = {5'b0, ovr_q, !tx_busy, rx_rdy_q};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q    <= 1'b0;
      rdata_q  <= '0;
      rx_rdy_q <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      ack_q   <= acc;
      rdata_q <= rd ? rd_mux : '0;
      if (rx_done)      rx_rdy_q <= 1'b1;
      else if (rd_data) rx_rdy_q <= 1'b0;
      if (rx_done && rx_rdy_q && !rd_data) ovr_q <= 1'b1;
      else if (rd_stat)                    ovr_q <= 1'b0;
    end
  end

  assign ack_o    = ack_q;
  assign rdata_o  = rdata_q;
  assign tx_irq_o = !tx_busy;
  assign rx_irq_o = rx_rdy_q;

  a_r9_ack_after_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(stb_i));
  a_r9_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  a_r2_irq_drops_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_load && tx_irq_o) |=> !tx_irq_o);
  a_r4_irq_from_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_irq_o) |-> $past(rx_done));
  a_r5_read_clears_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && !rx_done) |=> !rx_irq_o);
  a_r8_overrun_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $past(rx_done && rx_irq_o));
endmodule

// File: tb/uart_bus_slave_tb.sv
module uart_bus_slave_tb;
  localparam int DIV = 4;
  localparam int BIT = 16 * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b0, we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       ack, txd, tx_irq, rx_irq;
  logic       rxd = 1'b1;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  uart_bus_slave #(.CLK_PER_TICK(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .stb_i(stb), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ack_o(ack), .txd_o(txd),
    .rxd_i(rxd), .tx_irq_o(tx_irq), .rx_irq_o(rx_irq)
  );

  function automatic logic frame_bit(input logic [7:0] b, input int k);
    if (k == 0) return 1'b0;
    if (k == 9) return 1'b1;
    return b[k-1];
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    stb = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    stb = 1'b0; we = 1'b0;
    chk({7'b0, ack}, 8'h01, "R9 write ack");
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d, output logic irq_at_ack);
    stb = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    stb = 1'b0;
    chk({7'b0, ack}, 8'h01, "R9 read ack");
    d = rdata;
    irq_at_ack = rx_irq;
    @(negedge clk);
    chk({7'b0, ack}, 8'h00, "R9 ack one cycle");
  endtask

  // called right after bus_write: index 0 is half a cycle after the accepting edge
  task automatic tx_capture(input logic [7:0] b, input bit inject);
    for (int n = 0; n < 12 * BIT; n++) begin
      if (inject && n == 100) begin
        stb = 1'b1; we = 1'b1; addr = 2'd0; wdata = ~b;
      end
      if (inject && n == 101) begin
        stb = 1'b0; we = 1'b0;
      end
      if (n % BIT == BIT / 2 && n < 10 * BIT)
        chk({7'b0, txd}, {7'b0, frame_bit(b, n / BIT)}, "R1 tx bit");
      if (n == 0)           chk({7'b0, tx_irq}, 8'h00, "R2 irq low at start");
      if (n == 10 * BIT - 1) chk({7'b0, tx_irq}, 8'h00, "R2 irq low to end");
      if (n == 10 * BIT)     chk({7'b0, tx_irq}, 8'h01, "R2 irq rises");
      if (n == 11 * BIT)     chk({7'b0, txd}, 8'h01, "R3 no second frame");
      @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input bit stop_low);
    for (int k = 0; k < 10; k++) begin
      rxd = frame_bit(b, k);
      if (k == 9 && stop_low) begin
        rxd = 1'b0;
        repeat (BIT / 2 + 8) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT / 2 - 8) @(negedge clk);
      end else begin
        repeat (BIT) @(negedge clk);
      end
    end
    rxd = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic irq;
    int unsigned seed_v;
    seed_v = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({7'b0, txd}, 8'h01, "R11 txd");
    chk({7'b0, tx_irq}, 8'h01, "R11 tx_irq");
    chk({7'b0, rx_irq}, 8'h00, "R11 rx_irq");
    chk({7'b0, ack}, 8'h00, "R11 ack");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10 status and unused addresses
    bus_read(2'd1, d, irq); chk(d, 8'h02, "R10 status idle");
    bus_read(2'd3, d, irq); chk(d, 8'h00, "R10 addr3 zero");
    bus_read(2'd2, d, irq); chk(d, 8'h00, "R10 addr2 zero");
    bus_write(2'd1, 8'hFF);
    @(negedge clk);
    chk({7'b0, txd}, 8'h01, "R10 status write no tx");
    bus_read(2'd1, d, irq); chk(d, 8'h02, "R10 status unchanged");

    // R1 R2 R3 directed, with mid-frame write
    bus_write(2'd0, 8'hA5);
    tx_capture(8'hA5, 1'b1);
    // R1 random bytes
    for (int i = 0; i < 3; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      bus_write(2'd0, b);
      tx_capture(b, 1'b0);
    end

    // R4 R5 directed receive
    send_frame(8'h5A, 1'b0);
    chk({7'b0, rx_irq}, 8'h01, "R4 rx_irq high");
    bus_read(2'd1, d, irq); chk(d, 8'h03, "R10 status rx ready");
    bus_read(2'd0, d, irq);
    chk(d, 8'h5A, "R4 rx data");
    chk({7'b0, irq}, 8'h00, "R5 irq low at ack");
    bus_read(2'd1, d, irq); chk(d, 8'h02, "R5 status cleared");

    for (int i = 0; i < 3; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      send_frame(b, 1'b0);
      chk({7'b0, rx_irq}, 8'h01, "R4 rx_irq random");
      bus_read(2'd0, d, irq);
      chk(d, b, "R4 rx data random");
      chk({7'b0, irq}, 8'h00, "R5 irq cleared random");
    end

    // R6 glitch rejection
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BIT) @(negedge clk);
    chk({7'b0, rx_irq}, 8'h00, "R6 glitch no irq");
    send_frame(8'h81, 1'b0);
    chk({7'b0, rx_irq}, 8'h01, "R6 frame after glitch");
    bus_read(2'd0, d, irq); chk(d, 8'h81, "R6 data after glitch");

    // R7 bad stop bit
    send_frame(8'h77, 1'b1);
    repeat (2 * BIT) @(negedge clk);
    chk({7'b0, rx_irq}, 8'h00, "R7 bad stop no irq");
    bus_read(2'd1, d, irq); chk(d, 8'h02, "R7 status after bad stop");

    // R8 overrun
    send_frame(8'h11, 1'b0);
    send_frame(8'h22, 1'b0);
    bus_read(2'd1, d, irq); chk(d, 8'h07, "R8 overrun flag");
    bus_read(2'd0, d, irq); chk(d, 8'h22, "R8 data replaced");
    bus_read(2'd1, d, irq); chk(d, 8'h02, "R8 overrun cleared");

    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule